// File: doc/BRIEF.md
# Write-Leveling Strobe Delay Sweep Calibrator

This block runs a hardware write-leveling calibration across several byte lanes of a DDR3-style memory interface. A start pulse begins a sweep of the strobe delay. The delay starts at step zero and rises one step at a time until it has covered one full clock period. With the default width there are 256 steps, so one step is CK/256.

At every step the block raises a probe request toward the PHY side. It keeps the request up until a sample-valid strobe returns one feedback bit per lane. For each lane, the block watches the sampled bits for the first place where a 0 is later followed by a 1. The step of that 1 becomes the lane's calibrated delay.

When the sweep ends, the block reports a delay result and an error flag for each lane. It raises done for one cycle. A lane whose sweep holds no 0-then-1 edge is flagged as an error and reports a delay of zero.

Top module: `wl_sweep_cal`

## Requirements
- R1: After a synchronous reset, busy, done, probe_req, every lane_dly field and every lane_err bit are 0.
- R2: A start pulse while idle makes busy and probe_req high from the next cycle, with probe_dly equal to 0.
- R3: probe_dly stays stable while probe_req waits for sample_valid. Each sample accepted (probe_req and sample_valid high together) moves probe_dly up by one, so sample k of a sweep is taken at probe_dly = k.
- R4: The sweep holds exactly 2**DLY_W accepted samples. In the cycle after the sample at step 2**DLY_W-1 is accepted, done is 1 for exactly one cycle, while busy and probe_req are 0.
- R5: Lane i uses bit i of sample_fb. Its result, in field lane_dly[i*DLY_W +: DLY_W], is the step of the first sample that is 1 and has an earlier 0 sample in the same sweep. Any edges after that one have no effect on the result.
- R6: Leading 1 samples, including a 1 at step 0, count as no edge. The search waits for a 0 and then a 1.
- R7: A lane whose sweep holds no 0-then-1 edge has lane_err[i] set to 1 and its result set to 0. This applies to a lane that is all ones, all zeros, or ones followed only by zeros. A lane that does find an edge has lane_err[i] set to 0.
- R8: Results and error bits hold their values after done until the next accepted start, which clears them. A start pulse during a sweep is ignored and does not disturb the step sequence or the results.
- R9: Lanes are searched independently. One lane's feedback never changes another lane's result or error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle pulse that starts a sweep when the block is idle |
| probe_req | output | 1 | Probe request to the PHY for the current step |
| probe_dly | output | DLY_W | Strobe delay step applied to all lanes |
| sample_valid | input | 1 | Feedback is valid; accepted while probe_req is high |
| sample_fb | input | LANES | One sampled feedback bit per lane |
| busy | output | 1 | High while a sweep is in progress |
| done | output | 1 | One-cycle pulse when the sweep has finished |
| lane_dly | output | LANES*DLY_W | Per-lane calibrated delay, lane i in bits i*DLY_W +: DLY_W |
| lane_err | output | LANES | Per-lane flag: no 0-then-1 edge was found |

## Verification
The assertions assume that start is a one-cycle pulse. They also assume that sample_fb is valid whenever sample_valid is high during a probe request. The PHY model in the bench therefore asserts sample_valid only while probe_req is high, and holds it for exactly one cycle per step. It chooses the feedback bits from a per-lane pattern indexed by the probe_dly the block presents. Some scenarios insert a response latency of one or two cycles so that the delay-hold property is exercised. One scenario drives a stray start pulse mid-sweep to show that it has no effect.

// File: rtl/wl_cal_pkg.sv
package wl_cal_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PROBE = 2'd1,
      ST_FIN   = 2'd2
   } wl_state_e;
endpackage

// File: rtl/wl_sweep_seq.sv
module wl_sweep_seq
   import wl_cal_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             sample_valid,
   output logic             probe_req,
   output logic [DLY_W-1:0] probe_dly,
   output logic             busy,
   output logic             done,
   output logic             clr,
   output logic             smp,
   output logic             last
);
   localparam logic [DLY_W-1:0] STEP_MAX = '1;

   wl_state_e        state_q;
   logic [DLY_W-1:0] step_q;

   assign probe_req = (state_q == ST_PROBE);
   assign busy      = probe_req;
   assign done      = (state_q == ST_FIN);
   assign probe_dly = step_q;
   assign clr       = (state_q == ST_IDLE) && start;
   assign smp       = probe_req && sample_valid;
   assign last      = smp && (step_q == STEP_MAX);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_PROBE;
                  step_q  <= '0;
               end
            end
            ST_PROBE: begin
               if (sample_valid) begin
                  if (step_q == STEP_MAX) state_q <= ST_FIN;
                  else                    step_q  <= step_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R2
   start_launch_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy && !done && start) |=> (busy && probe_req && probe_dly == '0));

   // R3
   dly_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (probe_req && !sample_valid) |=> (probe_req && $stable(probe_dly)));

   // R3
   dly_step_chk: assert property (@(posedge clk) disable iff (rst)
      (probe_req && sample_valid && probe_dly != STEP_MAX) |=>
         (probe_req && probe_dly == $past(probe_dly) + 1'b1));

   // R4
   done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
      (probe_req && sample_valid && probe_dly == STEP_MAX) |=> (done && !busy && !probe_req));

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
endmodule

// File: rtl/wl_lane_search.sv
module wl_lane_search #(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             smp,
   input  logic             last,
   input  logic [DLY_W-1:0] step,
   input  logic             fb,
   output logic [DLY_W-1:0] res,
   output logic             err
);
   logic seen0_q;
   logic found_q;
   logic hit;

   assign hit = !found_q && seen0_q && fb;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         seen0_q <= 1'b0;
         found_q <= 1'b0;
         res     <= '0;
         err     <= 1'b0;
      end else if (smp) begin
         if (!fb) begin
            seen0_q <= 1'b1;
         end
         if (hit) begin
            found_q <= 1'b1;
            res     <= step;
         end
         if (last) begin
            err <= !(found_q || hit);
         end
      end
   end

   // R7
   err_zero_res_chk: assert property (@(posedge clk) disable iff (rst)
      err |-> (res == '0));

   // R8
   result_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr && !smp) |=> ($stable(res) && $stable(err)));

   // R6
   lead_one_chk: assert property (@(posedge clk) disable iff (rst)
      (smp && fb && !seen0_q && !found_q) |=> $stable(res));
endmodule

// File: rtl/wl_sweep_cal.sv
module wl_sweep_cal #(
   parameter int LANES = 4,
   parameter int DLY_W = 8
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   start,
   output logic                   probe_req,
   output logic [DLY_W-1:0]       probe_dly,
   input  logic                   sample_valid,
   input  logic [LANES-1:0]       sample_fb,
   output logic                   busy,
   output logic                   done,
   output logic [LANES*DLY_W-1:0] lane_dly,
   output logic [LANES-1:0]       lane_err
);
   localparam int STEPS = 1 << DLY_W;

   logic clr;
   logic smp;
   logic last;

   initial begin
      lanes_param_chk: assert (LANES >= 1 && LANES <= 32)
         else $error("LANES out of range");
      dly_param_chk: assert (DLY_W >= 2 && DLY_W <= 12 && STEPS >= 4)
         else $error("DLY_W out of range");
   end

   wl_sweep_seq #(.DLY_W(DLY_W)) u_seq (
      .clk          (clk),
      .rst          (rst),
      .start        (start),
      .sample_valid (sample_valid),
      .probe_req    (probe_req),
      .probe_dly    (probe_dly),
      .busy         (busy),
      .done         (done),
      .clr          (clr),
      .smp          (smp),
      .last         (last)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      wl_lane_search #(.DLY_W(DLY_W)) u_lane (
         .clk  (clk),
         .rst  (rst),
         .clr  (clr),
         .smp  (smp),
         .last (last),
         .step (probe_dly),
         .fb   (sample_fb[i]),
         .res  (lane_dly[i*DLY_W +: DLY_W]),
         .err  (lane_err[i])
      );
   end

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy && !clr) |=> (!busy && $stable(lane_err)));
endmodule

// File: tb/wl_sweep_cal_tb.sv
module wl_sweep_cal_tb;
   localparam int LANES = 4;
   localparam int DLY_W = 8;
   localparam int STEPS = 1 << DLY_W;

   logic                   clk = 1'b0;
   logic                   rst = 1'b1;
   logic                   start = 1'b0;
   logic                   probe_req;
   logic [DLY_W-1:0]       probe_dly;
   logic                   sample_valid = 1'b0;
   logic [LANES-1:0]       sample_fb = '0;
   logic                   busy;
   logic                   done;
   logic [LANES*DLY_W-1:0] lane_dly;
   logic [LANES-1:0]       lane_err;

   int n_chk = 0;
   int n_bad = 0;
   logic [STEPS-1:0] pat [LANES];

   always #10 clk = ~clk;

   wl_sweep_cal #(.LANES(LANES), .DLY_W(DLY_W)) u_dut (
      .clk(clk), .rst(rst), .start(start), .probe_req(probe_req), .probe_dly(probe_dly),
      .sample_valid(sample_valid), .sample_fb(sample_fb), .busy(busy), .done(done),
      .lane_dly(lane_dly), .lane_err(lane_err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_res(input logic [STEPS-1:0] p);
      bit z = 0;
      for (int s = 0; s < STEPS; s++) begin
         if (!p[s]) z = 1;
         else if (z) return s;
      end
      return -1;
   endfunction

   function automatic logic [STEPS-1:0] ones_from(input int k);
      logic [STEPS-1:0] v = '0;
      for (int s = 0; s < STEPS; s++) if (s >= k) v[s] = 1'b1;
      return v;
   endfunction

   task automatic check_lanes(input string tag);
      for (int i = 0; i < LANES; i++) begin
         int e = exp_res(pat[i]);
         int r = int'(lane_dly[i*DLY_W +: DLY_W]);
         if (e < 0) begin
            chk(lane_err[i] === 1'b1, {tag, " R7 lane err"}, int'(lane_err[i]), 1);
            chk(r == 0, {tag, " R7 err lane result"}, r, 0);
         end else begin
            chk(lane_err[i] === 1'b0, {tag, " R9 lane no err"}, int'(lane_err[i]), 0);
            chk(r == e, {tag, " R5 lane result"}, r, e);
         end
      end
   endtask

   task automatic sweep(input int lat, input bit stray_start, input string tag);
      int bad_seq = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(busy && probe_req && probe_dly == 0, {tag, " R2 launch"}, int'(probe_dly), 0);
      for (int s = 0; s < STEPS; s++) begin
         for (int w = 0; w < lat; w++) @(negedge clk);
         if (!probe_req || int'(probe_dly) != s) bad_seq++;
         for (int i = 0; i < LANES; i++) sample_fb[i] = pat[i][probe_dly];
         sample_valid = 1'b1;
         if (stray_start && s == 100) start = 1'b1;
         @(negedge clk);
         sample_valid = 1'b0;
         start = 1'b0;
      end
      chk(bad_seq == 0, {tag, " R3 step sequence"}, bad_seq, 0);
      chk(done === 1'b1 && busy === 1'b0 && probe_req === 1'b0, {tag, " R4 done after last"},
          int'(done), 1);
      check_lanes(tag);
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, {tag, " R4 done single cycle"}, int'(done), 0);
   endtask

   task automatic t_reset();
      chk(!busy && !done && !probe_req, "R1 reset controls", int'(busy), 0);
      chk(lane_dly == '0 && lane_err == '0, "R1 reset results", int'(lane_err), 0);
   endtask

   task automatic t_clean();
      pat[0] = ones_from(1);
      pat[1] = ones_from(128);
      pat[2] = ones_from(255);
      pat[3] = ones_from(40);
      sweep(0, 1'b0, "clean");
   endtask

   task automatic t_leading_ones();
      pat[0] = ones_from(20);
      for (int s = 0; s < 10; s++) pat[0][s] = 1'b1;
      pat[1] = '1;
      pat[2] = '0;
      pat[3] = ones_from(255);
      pat[3][0] = 1'b1;
      sweep(2, 1'b0, "R6 lead");
   endtask

   task automatic t_glitch();
      for (int s = 0; s < STEPS; s++) pat[0][s] = s[0];
      pat[1] = ones_from(200);
      for (int s = 51; s <= 60; s++) pat[1][s] = 1'b1;
      pat[2] = ones_from(2);
      pat[2][0] = 1'b1;
      pat[2][1] = 1'b0;
      pat[3] = '0;
      pat[3][0] = 1'b1;
      sweep(1, 1'b1, "R8 glitch");
   endtask

   task automatic t_hold_clear();
      logic [LANES*DLY_W-1:0] d0 = lane_dly;
      logic [LANES-1:0]       e0 = lane_err;
      repeat (5) @(negedge clk);
      chk(lane_dly == d0, "R8 result hold", int'(lane_dly[DLY_W-1:0]), int'(d0[DLY_W-1:0]));
      chk(lane_err == e0 && !busy, "R8 err hold", int'(lane_err), int'(e0));
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(lane_err == '0 && lane_dly == '0, "R8 cleared by start", int'(lane_err), 0);
      pat[0] = '1;
      pat[1] = ones_from(7);
      pat[2] = ones_from(77);
      pat[3] = '1;
      for (int s = 0; s < STEPS; s++) begin
         for (int i = 0; i < LANES; i++) sample_fb[i] = pat[i][probe_dly];
         sample_valid = 1'b1;
         @(negedge clk);
         sample_valid = 1'b0;
      end
      check_lanes("R9 mixed");
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_clean();
      t_leading_ones();
      t_glitch();
      t_hold_clear();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule